// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block sits behind a byte-level serial front end on a multidrop command bus. It takes one received byte per cycle through a valid/data pair. It waits for a header byte, then compares the following address byte with the slave address supplied on an input. When the address matches, it reads a command byte and a run of printable data bytes up to a terminator byte, and finally compares a trailing check byte with the XOR of every byte from header through terminator.

The frame is judged by four named states: `S_IDLE` (waiting for a header), `S_ADDR` (header seen, waiting for the address), `S_DATA` (collecting the command, then data) and `S_CSUM` (terminator seen, waiting for the check byte). The transitions are: idle-to-addr on a header; addr-stays-addr on a repeated header (resync); addr-to-data on an address match; addr-to-idle on any other byte; data-to-csum on a terminator that arrives after the exact data count for the command; data-to-idle on an unknown command, a non-printable byte, a wrong count or buffer overflow (abort, no report); csum-to-idle on any byte, with a good or error pulse. The command set and each command's required data count come from parameters.

Top module: `addr_frame_rx`

## Requirements
- R1: After reset the receiver is in `S_IDLE`, `frame_ok` and `frame_err` are low, and `cmd_out` and `data_len` are zero.
- R2: In `S_IDLE` every byte other than the header 0x02 is ignored and produces no pulse.
- R3: The byte after the header is compared with `slave_addr`. A match moves to `S_DATA`. Any other byte (except the header) returns to `S_IDLE` and the frame is dropped silently.
- R4: A header 0x02 received in `S_ADDR` keeps the receiver in `S_ADDR` and restarts the frame, with the check value restarting from that header.
- R5: The first byte in `S_DATA` is the command. A code absent from the command table (defaults 0x41, 0x42, 0x43, 0x44 needing 0, 1, 3 and 16 data bytes) aborts to `S_IDLE`.
- R6: The terminator 0x03 moves to `S_CSUM` only when the number of data bytes received equals the command's required count. Otherwise it aborts to `S_IDLE`.
- R7: Only codes 0x20 through 0x7E are accepted as data bytes. Any other non-terminator byte in the data section aborts to `S_IDLE`.
- R8: At most DEPTH (16) data bytes are stored, byte i at `data_bytes[8i+7:8i]`. A data byte arriving when DEPTH are already held aborts to `S_IDLE`.
- R9: A check byte equal to the XOR of all bytes from header through terminator gives a one-cycle `frame_ok` in the cycle after that byte is accepted. With it, `cmd_out`, `data_len` and `data_bytes` show the frame's command, count and data. The receiver returns to `S_IDLE`.
- R10: A check byte that differs gives a one-cycle `frame_err` in the same cycle position and returns to `S_IDLE`.
- R11: `frame_ok` and `frame_err` are never high together, and `cmd_out` and `data_len` change only in a cycle where `frame_ok` is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_addr | input | 8 | Address this slave answers to |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| frame_ok | output | 1 | One-cycle pulse: frame accepted, check byte matched |
| frame_err | output | 1 | One-cycle pulse: check byte mismatch |
| cmd_out | output | 8 | Command of the last accepted frame |
| data_len | output | LEN_W (5) | Data byte count of the last accepted frame |
| data_bytes | output | DEPTH*8 (128) | Data buffer, byte i in bits 8i+7:8i |

## Verification
The assertions assume that `slave_addr` is stable while a frame is in flight and that the configured address is not the header code. They also assume that `rx_valid` carries one byte per cycle, with no meaning given to `rx_data` when it is low. The bench changes `slave_addr` only while the receiver is idle between frames and never uses 0x02 as an address. It holds `rx_valid` low between frames and lets the output pulses settle before the next frame, so each pulse can be attributed to exactly one frame.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_DATA = 2'd2,
        S_CSUM = 2'd3
    } afr_state_e;

    localparam logic [7:0] HDR_CODE   = 8'h02;
    localparam logic [7:0] TERM_CODE  = 8'h03;
    localparam logic [7:0] PRINT_LO   = 8'h20;
    localparam logic [7:0] PRINT_HI   = 8'h7E;

endpackage

// File: rtl/afr_cmd_lookup.sv
module afr_cmd_lookup #(
    parameter int                          NUM_CMDS  = 4,
    parameter int                          LEN_W     = 5,
    parameter logic [NUM_CMDS*8-1:0]       CMD_CODES = '0,
    parameter logic [NUM_CMDS*LEN_W-1:0]   CMD_LENS  = '0
) (
    input  logic [7:0]       code,
    output logic             hit,
    output logic [LEN_W-1:0] need
);

    logic [NUM_CMDS-1:0] match;

    generate
        for (genvar g = 0; g < NUM_CMDS; g++) begin : g_cmp
            assign match[g] = (code == CMD_CODES[g*8 +: 8]);
        end
    endgenerate

    always_comb begin
        need = '0;
        for (int i = 0; i < NUM_CMDS; i++) begin
            if (match[i]) begin
                need = need | CMD_LENS[i*LEN_W +: LEN_W];
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/afr_lrc.sv
module afr_lrc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       fold,
    input  logic [7:0] byte_in,
    output logic [7:0] acc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= byte_in;
        end else if (fold) begin
            acc <= acc ^ byte_in;
        end
    end

endmodule

// File: rtl/afr_data_buf.sv
module afr_data_buf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_byte,
    output logic [DEPTH*8-1:0] bytes_flat
);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            logic [7:0] slot_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot_q <= wr_byte;
                end
            end
            assign bytes_flat[g*8 +: 8] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/addr_frame_rx.sv
module addr_frame_rx
    import afr_pkg::*;
#(
    parameter int                        DEPTH     = 16,
    parameter int                        LEN_W     = 5,
    parameter int                        NUM_CMDS  = 4,
    parameter logic [NUM_CMDS*8-1:0]     CMD_CODES = {8'h44, 8'h43, 8'h42, 8'h41},
    parameter logic [NUM_CMDS*LEN_W-1:0] CMD_LENS  = {5'd16, 5'd3, 5'd1, 5'd0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         slave_addr,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               frame_ok,
    output logic               frame_err,
    output logic [7:0]         cmd_out,
    output logic [LEN_W-1:0]   data_len,
    output logic [DEPTH*8-1:0] data_bytes
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(DEPTH);

    afr_state_e       state;
    logic             have_cmd;
    logic [LEN_W-1:0] cnt;
    logic [7:0]       cmd_q;
    logic [LEN_W-1:0] need_q;

    logic             is_hdr, is_term, is_print, room;
    logic             cmd_hit;
    logic [LEN_W-1:0] cmd_need;
    logic             lrc_load, lrc_fold, buf_wr;
    logic [7:0]       lrc_acc;

    assign is_hdr   = (rx_data == HDR_CODE);
    assign is_term  = (rx_data == TERM_CODE);
    assign is_print = (rx_data >= PRINT_LO) && (rx_data <= PRINT_HI);
    assign room     = (cnt < FULL_CNT);

    afr_cmd_lookup #(
        .NUM_CMDS  (NUM_CMDS),
        .LEN_W     (LEN_W),
        .CMD_CODES (CMD_CODES),
        .CMD_LENS  (CMD_LENS)
    ) u_lookup (
        .code (rx_data),
        .hit  (cmd_hit),
        .need (cmd_need)
    );

    assign lrc_load = rx_valid && is_hdr && (state == S_IDLE || state == S_ADDR);
    assign lrc_fold = rx_valid && (state == S_ADDR || state == S_DATA);

    afr_lrc u_lrc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lrc_load),
        .fold    (lrc_fold),
        .byte_in (rx_data),
        .acc     (lrc_acc)
    );

    assign buf_wr = rx_valid && (state == S_DATA) && have_cmd && is_print && room;

    afr_data_buf #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (buf_wr),
        .wr_idx     (cnt[IDX_W-1:0]),
        .wr_byte    (rx_data),
        .bytes_flat (data_bytes)
    );

    // State register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            have_cmd <= 1'b0;
            cnt      <= '0;
            cmd_q    <= '0;
            need_q   <= '0;
        end else if (rx_valid) begin
            unique case (state)
                S_IDLE: begin
                    if (is_hdr) state <= S_ADDR;
                end
                S_ADDR: begin
                    if (is_hdr) begin
                        state <= S_ADDR;
                    end else if (rx_data == slave_addr) begin
                        state    <= S_DATA;
                        have_cmd <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_DATA: begin
                    if (!have_cmd) begin
                        if (cmd_hit) begin
                            have_cmd <= 1'b1;
                            cmd_q    <= rx_data;
                            need_q   <= cmd_need;
                        end else begin
                            state <= S_IDLE;
                        end
                    end else if (is_term) begin
                        state <= (cnt == need_q) ? S_CSUM : S_IDLE;
                    end else if (is_print && room) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_CSUM: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
            cmd_out   <= '0;
            data_len  <= '0;
        end else begin
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
            if (rx_valid && state == S_CSUM) begin
                if (rx_data == lrc_acc) begin
                    frame_ok <= 1'b1;
                    cmd_out  <= cmd_q;
                    data_len <= cnt;
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && rx_valid && rx_data != HDR_CODE) |=> (state == S_IDLE)); // R2
    AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && rx_valid && rx_data != HDR_CODE && rx_data != slave_addr)
        |=> (state == S_IDLE && !frame_ok)); // R3
    AST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && rx_valid && rx_data == HDR_CODE) |=> (state == S_ADDR && lrc_acc == HDR_CODE)); // R4
    AST_BAD_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && have_cmd && rx_valid && rx_data != TERM_CODE
         && (rx_data < PRINT_LO || rx_data > PRINT_HI)) |=> (state == S_IDLE)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= FULL_CNT)); // R8
    AST_OK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> $past(state == S_CSUM && rx_valid)); // R9
    AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok); // R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> (!frame_err && state != S_CSUM)); // R10
    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_err)); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |-> ($stable(cmd_out) && $stable(data_len))); // R11

endmodule

// File: tb/addr_frame_rx_bench.sv
`timescale 1ns/1ps
module addr_frame_rx_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   slave_addr = 8'h5A;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = 8'h00;
    logic         frame_ok, frame_err;
    logic [7:0]   cmd_out;
    logic [4:0]   data_len;
    logic [127:0] data_bytes;

    int tests = 0;
    int fails = 0;
    int ok_seen = 0;
    int err_seen = 0;
    bit done = 1'b0;
    logic [7:0] lrc_acc;

    always #2 clk = ~clk;

    addr_frame_rx u_addr_frame_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_addr (slave_addr),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .frame_ok   (frame_ok),
        .frame_err  (frame_err),
        .cmd_out    (cmd_out),
        .data_len   (data_len),
        .data_bytes (data_bytes)
    );

    always @(negedge clk) begin
        if (frame_ok)  ok_seen++;
        if (frame_err) err_seen++;
    end

    // addr[31:24] cmd[23:16] ndata[15:8] bad[7:4] expect[3:0] (0 none, 1 ok, 2 err)
    localparam logic [31:0] VEC [9] = '{
        {8'h5A, 8'h41, 8'd0,  4'd0, 4'd1},   // R9 no data
        {8'h5A, 8'h42, 8'd1,  4'd0, 4'd1},   // R9 one data byte
        {8'h5A, 8'h43, 8'd3,  4'd0, 4'd1},   // R5 R9
        {8'h5A, 8'h44, 8'd16, 4'd0, 4'd1},   // R8 full buffer
        {8'h5A, 8'h43, 8'd3,  4'd1, 4'd2},   // R10 bad check byte
        {8'h5B, 8'h41, 8'd0,  4'd0, 4'd0},   // R3 other slave
        {8'h5A, 8'h43, 8'd2,  4'd0, 4'd0},   // R6 short
        {8'h5A, 8'h45, 8'd0,  4'd0, 4'd0},   // R5 unknown
        {8'h5A, 8'h44, 8'd17, 4'd0, 4'd0}    // R8 overflow
    };

    task automatic check(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        lrc_acc  = lrc_acc ^ b;
        @(negedge clk);
    endtask

    task automatic idle_gap();
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c,
                              input int n, input bit bad);
        lrc_acc = 8'h00;
        put(8'h02);
        put(a);
        put(c);
        for (int i = 0; i < n; i++) put(8'h30 + 8'(i));
        put(8'h03);
        put(bad ? ~lrc_acc : lrc_acc);
        idle_gap();
    endtask

    task automatic check_pulses(input string req, input int ok0, input int err0,
                                input int exp_ok, input int exp_err);
        check(ok_seen - ok0 == exp_ok, {req, " frame_ok count"}, ok_seen - ok0, exp_ok);
        check(err_seen - err0 == exp_err, {req, " frame_err count"}, err_seen - err0, exp_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ok0, err0;
        logic [7:0] prev_cmd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!frame_ok && !frame_err, "R1 pulses low in reset", {frame_ok, frame_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_out == 8'h00, "R1 cmd_out after reset", cmd_out, 0);
        check(data_len == 5'd0, "R1 data_len after reset", data_len, 0);

        // Vector table
        foreach (VEC[k]) begin
            logic [7:0] va, vc;
            int vn;
            bit vb;
            int ve;
            bit same;
            va = VEC[k][31:24]; vc = VEC[k][23:16]; vn = int'(VEC[k][15:8]);
            vb = VEC[k][4];     ve = int'(VEC[k][3:0]);
            ok0 = ok_seen; err0 = err_seen; prev_cmd = cmd_out;
            send_frame(va, vc, vn, vb);
            check_pulses($sformatf("R9/R10 vector %0d", k), ok0, err0,
                         (ve == 1) ? 1 : 0, (ve == 2) ? 1 : 0);
            if (ve == 1) begin
                check(cmd_out == vc, "R9 cmd_out", cmd_out, vc);
                check(data_len == 5'(vn), "R9 data_len", data_len, vn);
                same = 1'b1;
                for (int i = 0; i < vn; i++)
                    if (data_bytes[i*8 +: 8] != 8'h30 + 8'(i)) same = 1'b0;
                check(same, "R8 data_bytes contents", 0, 0);
            end else begin
                check(cmd_out == prev_cmd, "R11 cmd_out held", cmd_out, prev_cmd);
            end
        end

        // R2 idle ignores junk, then a frame still works
        ok0 = ok_seen; err0 = err_seen;
        lrc_acc = 8'h00;
        put(8'h41); put(8'h03); put(8'h5A); put(8'hFF);
        idle_gap();
        check_pulses("R2 junk in idle", ok0, err0, 0, 0);
        send_frame(8'h5A, 8'h42, 1, 1'b0);
        check_pulses("R2 frame after junk", ok0, err0, 1, 0);

        // R4 repeated header restarts frame and check value
        ok0 = ok_seen; err0 = err_seen;
        put(8'h02);
        lrc_acc = 8'h00;
        put(8'h02); put(8'h5A); put(8'h43);
        put(8'h61); put(8'h62); put(8'h63);
        put(8'h03); put(lrc_acc);
        idle_gap();
        check_pulses("R4 resync", ok0, err0, 1, 0);
        check(data_len == 5'd3, "R4 data_len", data_len, 3);

        // R7 non-printable aborts; edges 0x20 and 0x7E accepted
        ok0 = ok_seen; err0 = err_seen;
        lrc_acc = 8'h00;
        put(8'h02); put(8'h5A); put(8'h43); put(8'h30); put(8'h7F); put(8'h31);
        put(8'h03); put(lrc_acc);
        idle_gap();
        check_pulses("R7 0x7F aborts", ok0, err0, 0, 0);
        lrc_acc = 8'h00;
        put(8'h02); put(8'h5A); put(8'h43); put(8'h20); put(8'h7E); put(8'h41);
        put(8'h03); put(lrc_acc);
        idle_gap();
        check_pulses("R7 edge codes", ok0, err0, 1, 0);
        check(data_bytes[15:0] == 16'h7E20, "R7 stored edge codes", data_bytes[15:0], 16'h7E20);

        // R5 terminator instead of command aborts
        ok0 = ok_seen; err0 = err_seen;
        lrc_acc = 8'h00;
        put(8'h02); put(8'h5A); put(8'h03); put(lrc_acc);
        idle_gap();
        check_pulses("R5 missing command", ok0, err0, 0, 0);

        // R6 too many data bytes for command
        send_frame(8'h5A, 8'h42, 2, 1'b0);
        check_pulses("R6 long", ok0, err0, 0, 0);

        // R3 new slave address
        slave_addr = 8'h11;
        @(negedge clk);
        send_frame(8'h5A, 8'h41, 0, 1'b0);
        check_pulses("R3 old address dropped", ok0, err0, 0, 0);
        send_frame(8'h11, 8'h44, 16, 1'b0);
        check_pulses("R3 new address", ok0, err0, 1, 0);
        check(data_len == 5'd16, "R8 data_len 16", data_len, 16);

        // R10 error then return to idle: next good frame accepted
        send_frame(8'h11, 8'h41, 0, 1'b1);
        send_frame(8'h11, 8'h41, 0, 1'b0);
        check_pulses("R10 err then ok", ok0, err0, 2, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule